// File: doc/BRIEF.md
# Word-Granular Shared Registry Bank

This block is a bank of the shared cache level. It also acts as the coherence directory for a protocol that tracks state word by word. Each word holds one state bit, Valid or Registered. When the word is Valid, the data field holds the current value. When the word is Registered, the same data field holds the index of the single core that owns the latest copy. No sharer list exists, and no storage is added for directory information.

Cores send three kinds of request: read, register and writeback. A register request makes the requester the owner and returns an acknowledge. A read of a Valid word returns the data. A read of a Registered word returns a forward response, which names the owner core that will supply the data. A writeback from the current owner stores the value and makes the word Valid again. A writeback from any other core is acknowledged and dropped. The bank never sends an invalidation.

The bank accepts one request per cycle through a valid/ready handshake. It answers one cycle after acceptance through a one-entry response register that holds its contents under backpressure.

Top module: `registry_bank`

## Requirements
- R1: After reset every word is Valid and holds zero, `rsp_valid` is low and `req_ready` is high.
- R2: A read (`req_op`=0) of a Valid word gives, on the cycle after acceptance, a response of kind 0 (data) to the requester, with `rsp_data` equal to the stored value and `rsp_owner`=0.
- R3: A register request (`req_op`=1) makes the word Registered with the requester's index in the low `ID_W` bits of its data field. The response is kind 2 (register acknowledge) to the requester.
- R4: A read of a Registered word gives a response of kind 1 (forward). `rsp_core` is the requester and `rsp_owner` is the owning core.
- R5: A register request to a word that another core has already registered overwrites the owner.
- R6: A writeback (`req_op`=2) from the current owner stores `req_data` and makes the word Valid. The response is kind 3 (writeback acknowledge).
- R7: A writeback from a core that is not the owner, or to a Valid word, is answered with kind 3 and leaves the word's state and contents unchanged.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response is held stable and `req_ready` is low.
- R9: A request changes only the word it addresses.
- R10: The owner index is `ID_W` = clog2(`NUM_CORES`) bits wide, which is 6 bits for 64 cores. The largest index, 63, is stored and returned intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request this cycle |
| req_op | input | 2 | 0 read, 1 register, 2 writeback |
| req_core | input | ID_W | Index of the requesting core |
| req_addr | input | ADDR_W | Word index |
| req_data | input | DATA_W | Writeback value |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle |
| rsp_kind | output | 2 | 0 data, 1 forward, 2 register ack, 3 writeback ack |
| rsp_core | output | ID_W | Core the response goes to |
| rsp_owner | output | ID_W | Owner core for a forward, otherwise 0 |
| rsp_addr | output | ADDR_W | Word index of the request |
| rsp_data | output | DATA_W | Stored value for a data response, otherwise 0 |

## Verification
On every cycle the assertions check the following. An accepted read is answered with a data or forward response. An accepted register request is answered with an acknowledge to the same core. A writeback is always acknowledged. A stalled response stays frozen and blocks new requests. Only the bench scenarios can show what the stored state does over a sequence of requests. These cover a stale writeback that is dropped, a re-registration that replaces the owner, owner index 63, and a neighbouring word that stays untouched. They also cover what a later read reveals after each of these.

// File: rtl/registry_pkg.sv
package registry_pkg;
   typedef enum logic [1:0] {
      OP_READ = 2'd0,
      OP_REG  = 2'd1,
      OP_WB   = 2'd2
   } op_e;

   typedef enum logic [1:0] {
      K_DATA  = 2'd0,
      K_FWD   = 2'd1,
      K_REGAK = 2'd2,
      K_WBAK  = 2'd3
   } kind_e;
endpackage

// File: rtl/registry_store.sv
module registry_store #(
   parameter int WORDS  = 16,
   parameter int DATA_W = 32,
   localparam int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_reg,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_reg,
   input  logic [DATA_W-1:0] wr_data
);
   logic [WORDS-1:0]  st_q;
   logic [DATA_W-1:0] fld_q [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(w));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[w]  <= 1'b0;
            fld_q[w] <= '0;
         end else if (hit) begin
            st_q[w]  <= wr_reg;
            fld_q[w] <= wr_data;
         end
      end
   end

   assign rd_reg  = st_q[rd_addr];
   assign rd_data = fld_q[rd_addr];
endmodule

// File: rtl/registry_ctrl.sv
module registry_ctrl
   import registry_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ID_W   = 6
) (
   input  logic [1:0]        op,
   input  logic [ID_W-1:0]   core,
   input  logic [DATA_W-1:0] wb_data,
   input  logic              cur_reg,
   input  logic [DATA_W-1:0] cur_fld,
   output logic              wr_en,
   output logic              wr_reg,
   output logic [DATA_W-1:0] wr_data,
   output logic [1:0]        kind,
   output logic [ID_W-1:0]   owner,
   output logic [DATA_W-1:0] out_data
);
   logic [ID_W-1:0]   cur_owner;
   logic              is_owner;
   logic [DATA_W-1:0] id_word;

   assign cur_owner = cur_fld[ID_W-1:0];
   assign is_owner  = cur_reg && (cur_owner == core);

   always_comb begin
      id_word = '0;
      id_word[ID_W-1:0] = core;
   end

   always_comb begin
      wr_en    = 1'b0;
      wr_reg   = 1'b0;
      wr_data  = '0;
      kind     = K_DATA;
      owner    = '0;
      out_data = '0;
      unique case (op)
         OP_REG: begin
            wr_en   = 1'b1;
            wr_reg  = 1'b1;
            wr_data = id_word;
            kind    = K_REGAK;
         end
         OP_WB: begin
            kind    = K_WBAK;
            wr_en   = is_owner;
            wr_reg  = 1'b0;
            wr_data = wb_data;
         end
         default: begin
            if (cur_reg) begin
               kind  = K_FWD;
               owner = cur_owner;
            end else begin
               kind     = K_DATA;
               out_data = cur_fld;
            end
         end
      endcase
   end
endmodule

// File: rtl/registry_rsp.sv
module registry_rsp #(
   parameter int DATA_W = 32,
   parameter int ID_W   = 6,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        in_kind,
   input  logic [ID_W-1:0]   in_core,
   input  logic [ID_W-1:0]   in_owner,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              free,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        rsp_kind,
   output logic [ID_W-1:0]   rsp_core,
   output logic [ID_W-1:0]   rsp_owner,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [DATA_W-1:0] rsp_data
);
   assign free = !rsp_valid || rsp_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_kind  <= '0;
         rsp_core  <= '0;
         rsp_owner <= '0;
         rsp_addr  <= '0;
         rsp_data  <= '0;
      end else if (load) begin
         rsp_valid <= 1'b1;
         rsp_kind  <= in_kind;
         rsp_core  <= in_core;
         rsp_owner <= in_owner;
         rsp_addr  <= in_addr;
         rsp_data  <= in_data;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_data)
         && $stable(rsp_core) && $stable(rsp_owner)) else $error("held response changed"); // R8
endmodule

// File: rtl/registry_bank.sv
module registry_bank
   import registry_pkg::*;
#(
   parameter int NUM_CORES = 64,
   parameter int WORDS     = 16,
   parameter int DATA_W    = 32,
   localparam int ID_W     = $clog2(NUM_CORES),
   localparam int ADDR_W   = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ID_W-1:0]   req_core,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        rsp_kind,
   output logic [ID_W-1:0]   rsp_core,
   output logic [ID_W-1:0]   rsp_owner,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [DATA_W-1:0] rsp_data
);
   if (DATA_W < ID_W) begin : g_bad_width
      $error("DATA_W must hold an owner index");
   end
   if (NUM_CORES < 2 || WORDS < 2) begin : g_bad_size
      $error("NUM_CORES and WORDS must be at least 2");
   end

   logic              acc;
   logic              cur_reg;
   logic [DATA_W-1:0] cur_fld;
   logic              wr_en, wr_reg, wr_go;
   logic [DATA_W-1:0] wr_data, out_data;
   logic [1:0]        kind;
   logic [ID_W-1:0]   owner;

   assign acc   = req_valid && req_ready;
   assign wr_go = acc && wr_en;

   registry_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(req_addr), .rd_reg(cur_reg), .rd_data(cur_fld),
      .wr_en(wr_go), .wr_addr(req_addr), .wr_reg(wr_reg), .wr_data(wr_data)
   );

   registry_ctrl #(.DATA_W(DATA_W), .ID_W(ID_W)) u_ctrl (
      .op(req_op), .core(req_core), .wb_data(req_data),
      .cur_reg(cur_reg), .cur_fld(cur_fld),
      .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
      .kind(kind), .owner(owner), .out_data(out_data)
   );

   registry_rsp #(.DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_rsp (
      .clk(clk), .rst_n(rst_n), .load(acc),
      .in_kind(kind), .in_core(req_core), .in_owner(owner),
      .in_addr(req_addr), .in_data(out_data),
      .free(req_ready),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
      .rsp_core(rsp_core), .rsp_owner(rsp_owner), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
   );

   AST_READ_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_op == OP_READ |=> rsp_valid && (rsp_kind == K_DATA || rsp_kind == K_FWD))
      else $error("read not answered"); // R2
   AST_REG_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_op == OP_REG |=> rsp_valid && rsp_kind == K_REGAK && rsp_core == $past(req_core))
      else $error("register not acknowledged"); // R3
   AST_WB_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_op == OP_WB |=> rsp_valid && rsp_kind == K_WBAK)
      else $error("writeback not acknowledged"); // R6
   AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |-> !req_ready) else $error("accepting while stalled"); // R8
   AST_FWD_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_kind == K_FWD |-> rsp_data == '0) else $error("forward carries data"); // R4
endmodule

// File: tb/sim_registry_bank.sv
`timescale 1ns/100ps
module sim_registry_bank;
   localparam int ID_W = 6, ADDR_W = 4, DATA_W = 32;
   localparam int NV = 15;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, rsp_ready = 1'b1;
   logic req_ready, rsp_valid;
   logic [1:0] req_op = '0, rsp_kind;
   logic [ID_W-1:0] req_core = '0, rsp_core, rsp_owner;
   logic [ADDR_W-1:0] req_addr = '0, rsp_addr;
   logic [DATA_W-1:0] req_data = '0, rsp_data;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   registry_bank u0 (.*);

   // fields: op(2) core(6) addr(4) data(32) kind(2) val(32); val = data or owner
   localparam logic [77:0] VEC [NV] = '{
      {2'd0, 6'd0,  4'd3,  32'h0,      2'd0, 32'h0},      // R1 R2 reset value
      {2'd1, 6'd5,  4'd3,  32'h0,      2'd2, 32'h0},      // R3
      {2'd0, 6'd9,  4'd3,  32'h0,      2'd1, 32'd5},      // R4
      {2'd1, 6'd63, 4'd3,  32'h0,      2'd2, 32'h0},      // R5 R10
      {2'd0, 6'd1,  4'd3,  32'h0,      2'd1, 32'd63},     // R5 R10
      {2'd2, 6'd5,  4'd3,  32'hAAAA,   2'd3, 32'h0},      // R7 stale owner
      {2'd0, 6'd2,  4'd3,  32'h0,      2'd1, 32'd63},     // R7
      {2'd2, 6'd63, 4'd3,  32'h1234,   2'd3, 32'h0},      // R6
      {2'd0, 6'd2,  4'd3,  32'h0,      2'd0, 32'h1234},   // R6
      {2'd2, 6'd7,  4'd3,  32'hFFFF,   2'd3, 32'h0},      // R7 valid word
      {2'd0, 6'd0,  4'd3,  32'h0,      2'd0, 32'h1234},   // R7
      {2'd1, 6'd2,  4'd15, 32'h0,      2'd2, 32'h0},      // R3
      {2'd0, 6'd4,  4'd14, 32'h0,      2'd0, 32'h0},      // R9 neighbour
      {2'd0, 6'd4,  4'd15, 32'h0,      2'd1, 32'd2},      // R4
      {2'd0, 6'd4,  4'd3,  32'h0,      2'd0, 32'h1234}    // R9
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [5:0] core,
                        input logic [3:0] addr, input logic [31:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_core = core; req_addr = addr; req_data = data;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      #100000;
      errors++; checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rsp_valid", 32'(rsp_valid), 0);
      chk("R1 req_ready", 32'(req_ready), 1);

      for (int i = 0; i < NV; i++) begin
         logic [77:0] v;
         v = VEC[i];
         issue(v[77:76], v[75:70], v[69:66], v[65:34]);
         chk($sformatf("R2-table vec%0d valid", i), 32'(rsp_valid), 1);
         chk($sformatf("vec%0d kind (R2/R3/R4/R6/R7)", i), 32'(rsp_kind), 32'(v[33:32]));
         chk($sformatf("vec%0d core", i), 32'(rsp_core), 32'(v[75:70]));
         chk($sformatf("vec%0d addr R9", i), 32'(rsp_addr), 32'(v[69:66]));
         if (v[33:32] == 2'd1) begin
            chk($sformatf("R4 vec%0d owner", i), 32'(rsp_owner), v[31:0]);
            chk($sformatf("R4 vec%0d data", i), rsp_data, 0);
         end else begin
            chk($sformatf("R2 vec%0d data", i), rsp_data, v[31:0]);
            chk($sformatf("R2 vec%0d owner", i), 32'(rsp_owner), 0);
         end
      end

      // R8 backpressure: response held, no acceptance
      @(negedge clk);
      rsp_ready = 1'b0;
      issue(2'd0, 6'd8, 4'd15, 32'h0);
      chk("R8 valid", 32'(rsp_valid), 1);
      chk("R8 ready low", 32'(req_ready), 0);
      req_valid = 1'b1; req_op = 2'd1; req_core = 6'd11; req_addr = 4'd15;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      chk("R8 kind held", 32'(rsp_kind), 1);
      chk("R8 owner held", 32'(rsp_owner), 2);
      chk("R8 core held", 32'(rsp_core), 8);
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R8 drained", 32'(rsp_valid), 0);
      issue(2'd0, 6'd8, 4'd15, 32'h0);
      chk("R8 blocked register ignored", 32'(rsp_owner), 2);

      // R1 reset clears state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      issue(2'd0, 6'd1, 4'd15, 32'h0);
      chk("R1 reset kind", 32'(rsp_kind), 0);
      chk("R1 reset data", rsp_data, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule